// File: doc/BRIEF.md
# Serial Result Shifter with Edge-Counted Framing

This block is the device-side serial output stage of a 12-bit converter. A serial clock from an external reader arrives with no fixed relation to the chip's system clock. The block samples that clock and the active-low convert-start input in the system clock domain and finds their edges. It counts serial clock edges to choose which bit of a 16-bit frame goes on the data output. A frame holds four zero bits and then the result, most significant bit first. The block drives a data bit and a separate output-enable for the pad buffer. It does not contain the tri-state buffer.

The conversion sequencer writes each finished result with a one-cycle load strobe. The shifter copies the stored result into its frame register when a frame starts, so a read that is already running is not disturbed. The reader may stop the serial clock at any point and go on later, for example a byte at a time. A falling edge of convert-start puts the frame counter back to its start, but only when the serial clock is low at that edge. If the serial clock is high at that edge, the counter keeps its position and a sticky warning flag is set.

Top module: `sdo_result_shifter`

## Requirements
- R1: While reset is asserted and after it is released, `sdata_oe` is 0, `sdata` is 0 and `sync_warn` is 0.
- R2: A frame is 16 bit positions. Positions 0 to 3 carry 0. Positions 4 to 15 carry result bits 11 down to 0, one bit per position.
- R3: `sdata_oe` stays 0 while the block is idle. It becomes 1 on the serial clock rising edge that opens a frame, and position 0 is presented then.
- R4: The presented bit moves to the next position only on a serial clock falling edge. It stays the same across the rising edge that follows.
- R5: The sixteenth falling edge ends a normal frame. After it, `sdata_oe` is 0 and the position counter is back at 0.
- R6: A rising edge after a completed frame, with no valid convert-start reset in between, starts the frame again from position 0. From then on `sdata_oe` stays 1 through frame wraps and while the clock is stopped.
- R7: A falling edge of `convst_n` while `sclk` is low returns the position to 0, sets `sdata_oe` to 0 and ends the restart mode of R6.
- R8: A falling edge of `convst_n` while `sclk` is high leaves the position and the output unchanged. It sets `sync_warn`, which stays 1 until reset.
- R9: Stopping `sclk` in the middle of a frame for any time keeps the position and `sdata_oe`. The rest of the frame follows on without a gap or a repeated bit.
- R10: A result written with `load_en` becomes the data of the next frame that starts. A load during a frame does not change the bits of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | External serial clock, idles low |
| convst_n | input | 1 | Active-low convert-start, asynchronous |
| load_en | input | 1 | One-cycle strobe that stores `load_data` |
| load_data | input | 12 | Conversion result from the sequencer |
| sdata | output | 1 | Serial data bit (0 when not driving) |
| sdata_oe | output | 1 | Output enable for the pad tri-state buffer |
| sync_warn | output | 1 | Sticky flag set by a convert-start fall while `sclk` is high |

## Verification
The assertions assume that the edges of `sclk` and `convst_n` are spaced far enough apart that a rising or falling serial edge is never seen in the same system cycle as a convert-start fall. The held-position check depends on this in particular. They also assume that each input level lasts several system clocks, so the two-stage synchronizer sees it. The bench keeps every input level for eight system clocks and changes only one input at a time. Inputs are driven on the falling system edge, so the synchronizer always sees clean levels.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  localparam int RES_W_DEF  = 12;
  localparam int LEAD_DEF   = 4;
  localparam int SYNC_STAGES_DEF = 2;

  // Bit presented at frame position pos: zeros first, then result MSB-first.
  function automatic logic frame_bit(input int pos, input int lead,
                                     input int res_w, input logic [31:0] word);
    logic [4:0] idx;
    if (pos < lead) return 1'b0;
    idx = 5'(res_w - 1 - (pos - lead));
    return word[idx];
  endfunction
endpackage

// File: rtl/sdo_edge_sync.sv
module sdo_edge_sync #(
  parameter int N = 2,
  parameter int STAGES = sdo_pkg::SYNC_STAGES_DEF,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0][STAGES:0] chain;

  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= {(STAGES+1){RST_VAL[g]}};
      else        chain[g] <= {chain[g][STAGES-1:0], din[g]};
    end
    assign level[g] = chain[g][STAGES-1];
    assign rise[g]  = chain[g][STAGES-1] & ~chain[g][STAGES];
    assign fall[g]  = ~chain[g][STAGES-1] & chain[g][STAGES];
  end
endmodule

// File: rtl/sdo_frame_ctrl.sv
module sdo_frame_ctrl #(
  parameter int RES_W = sdo_pkg::RES_W_DEF,
  parameter int LEAD  = sdo_pkg::LEAD_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_lvl,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             cnv_fall,
  input  logic [RES_W-1:0] hold_word,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             sync_warn
);
  localparam int FRAME = LEAD + RES_W;
  localparam int PW = $clog2(FRAME);
  localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

  logic [PW-1:0]    pos;
  logic             active, done, overrun, warn;
  logic [RES_W-1:0] snap;

  // Named events for the assertions
  logic cnv_reset, cnv_ignored, frame_start, last_fall;
  assign cnv_reset   = cnv_fall & ~sclk_lvl;
  assign cnv_ignored = cnv_fall & sclk_lvl;
  assign frame_start = sclk_rise & ~active;
  assign last_fall   = sclk_fall & active & (pos == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0; active <= 1'b0; done <= 1'b0; overrun <= 1'b0;
      snap <= '0;
    end else if (cnv_reset) begin
      pos <= '0; active <= 1'b0; done <= 1'b0; overrun <= 1'b0;
    end else if (frame_start) begin
      active <= 1'b1;
      pos    <= '0;
      snap   <= hold_word;
      if (done) overrun <= 1'b1;
    end else if (sclk_fall && active) begin
      if (pos == LAST) begin
        pos <= '0;
        if (overrun) snap <= hold_word;
        else begin
          active <= 1'b0;
          done   <= 1'b1;
        end
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warn <= 1'b0;
    else if (cnv_ignored) warn <= 1'b1;
  end

  assign sdata     = active ? sdo_pkg::frame_bit(int'(pos), LEAD, RES_W, 32'(snap)) : 1'b0;
  assign sdata_oe  = active;
  assign sync_warn = warn;

  AST_OE_OPENS_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(sclk_rise)) else $error("oe rose without sclk rise"); // R3
  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sclk_fall) && !$past(cnv_fall)) |-> $stable(sdata)) else $error("bit moved off a falling edge"); // R4
  AST_END_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fall && !overrun && !cnv_reset) |=> (!sdata_oe && pos == '0)) else $error("frame end kept driving"); // R5
  AST_OVERRUN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (last_fall && overrun && !cnv_reset) |=> (sdata_oe && pos == '0)) else $error("overrun wrap lost enable"); // R6
  AST_CNV_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_reset |=> (!sdata_oe && pos == '0 && !overrun)) else $error("convert-start reset missed"); // R7
  AST_CNV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_ignored && !sclk_rise) |=> (pos == $past(pos) && sync_warn)) else $error("ignored convert-start moved counter"); // R8
endmodule

// File: rtl/sdo_result_shifter.sv
module sdo_result_shifter #(
  parameter int RES_W = sdo_pkg::RES_W_DEF,
  parameter int LEAD  = sdo_pkg::LEAD_DEF,
  parameter int SYNC_STAGES = sdo_pkg::SYNC_STAGES_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             convst_n,
  input  logic             load_en,
  input  logic [RES_W-1:0] load_data,
  output logic             sdata,
  output logic             sdata_oe,
  output logic             sync_warn
);
  localparam int IDX_SCLK = 0;
  localparam int IDX_CNV  = 1;

  logic [1:0]       lvl, rise, fall;
  logic [RES_W-1:0] hold_word;

  sdo_edge_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({convst_n, sclk}),
    .level(lvl), .rise(rise), .fall(fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_word <= '0;
    else if (load_en) hold_word <= load_data;
  end

  sdo_frame_ctrl #(.RES_W(RES_W), .LEAD(LEAD)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_lvl(lvl[IDX_SCLK]), .sclk_rise(rise[IDX_SCLK]), .sclk_fall(fall[IDX_SCLK]),
    .cnv_fall(fall[IDX_CNV]), .hold_word(hold_word),
    .sdata(sdata), .sdata_oe(sdata_oe), .sync_warn(sync_warn)
  );
endmodule

// File: tb/sdo_result_shifter_tb_top.sv
module sdo_result_shifter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int NV = 6;
  // {result[11:0], pause_mid_frame}
  localparam logic [12:0] VEC [NV] = '{
    {12'hA5C, 1'b0}, {12'hFFF, 1'b1}, {12'h000, 1'b0},
    {12'h801, 1'b1}, {12'h3C3, 1'b0}, {12'h5A6, 1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, convst_n = 1'b1, load_en = 1'b0;
  logic [11:0] load_data = '0;
  logic sdata, sdata_oe, sync_warn;
  int checks = 0, fails = 0, hold_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdo_result_shifter dut_i (.clk(clk), .rst_n(rst_n), .sclk(sclk), .convst_n(convst_n),
    .load_en(load_en), .load_data(load_data), .sdata(sdata), .sdata_oe(sdata_oe),
    .sync_warn(sync_warn));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [11:0] v);
    @(negedge clk); load_data = v; load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic cnv_pulse();
    @(negedge clk); convst_n = 1'b0; wait_n(HALF);
    convst_n = 1'b1; wait_n(HALF);
  endtask

  task automatic rise_and_sample(output logic b, output logic oe);
    logic early;
    @(negedge clk); sclk = 1'b1; wait_n(4);
    early = sdata; oe = sdata_oe; wait_n(HALF - 4);
    b = sdata;
    if (early !== b) hold_err++;
  endtask

  task automatic fall_edge();
    @(negedge clk); sclk = 1'b0; wait_n(HALF);
  endtask

  task automatic read_bits(input int n, inout logic [15:0] w, inout logic oe_ok);
    logic b, oe;
    for (int i = 0; i < n; i++) begin
      rise_and_sample(b, oe);
      w = {w[14:0], b};
      oe_ok &= oe;
      fall_edge();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, w2;
    logic oe_ok, b, oe;
    wait_n(5);
    check(sdata_oe === 1'b0 && sdata === 1'b0 && sync_warn === 1'b0, "R1 in reset", {sdata_oe, sdata, sync_warn}, 0);
    rst_n = 1'b1; wait_n(5);
    check(sdata_oe === 1'b0 && sdata === 1'b0 && sync_warn === 1'b0, "R1 after reset", {sdata_oe, sdata, sync_warn}, 0);

    // Vector walk: R2, R3, R5, R9, R10
    for (int v = 0; v < NV; v++) begin
      load(VEC[v][12:1]);
      cnv_pulse();
      check(sdata_oe === 1'b0, "R3 idle before frame", sdata_oe, 0);
      w = '0; oe_ok = 1'b1;
      read_bits(8, w, oe_ok);
      if (VEC[v][0]) begin
        wait_n(60);
        check(sdata_oe === 1'b1, "R9 enable held in pause", sdata_oe, 1);
      end
      read_bits(8, w, oe_ok);
      check(w === {4'b0, VEC[v][12:1]}, "R2 frame word", w, {4'b0, VEC[v][12:1]});
      check(oe_ok === 1'b1, "R3 enable during frame", oe_ok, 1);
      check(sdata_oe === 1'b0, "R5 tri-state after 16th fall", sdata_oe, 0);
    end
    check(hold_err == 0, "R4 bit stable across rising edge", hold_err, 0);

    // R6 overrun restart
    load(12'h9B4); cnv_pulse();
    w = '0; oe_ok = 1'b1; read_bits(16, w, oe_ok);
    check(w === 16'h09B4, "R6 first frame", w, 16'h09B4);
    rise_and_sample(b, oe);
    check(oe === 1'b1 && b === 1'b0, "R6 restart at leading zero", {oe, b}, 2'b10);
    fall_edge();
    w2 = '0; oe_ok = 1'b1; read_bits(15, w2, oe_ok);
    check(w2 === 16'h09B4 && oe_ok, "R6 repeated frame", w2, 16'h09B4);
    wait_n(40);
    check(sdata_oe === 1'b1, "R6 enable stays after stop", sdata_oe, 1);

    // R7 valid convert-start reset
    cnv_pulse();
    check(sdata_oe === 1'b0, "R7 reset drops enable", sdata_oe, 0);
    load(12'h6D1); cnv_pulse();
    w = '0; oe_ok = 1'b1; read_bits(5, w, oe_ok);
    cnv_pulse();
    check(sdata_oe === 1'b0, "R7 mid-frame reset drops enable", sdata_oe, 0);
    w = '0; oe_ok = 1'b1; read_bits(16, w, oe_ok);
    check(w === 16'h06D1, "R7 frame restarts at position 0", w, 16'h06D1);

    // R8 convert-start fall with sclk high
    check(sync_warn === 1'b0, "R8 warn clear before event", sync_warn, 0);
    load(12'hC3A); cnv_pulse();
    w = '0; oe_ok = 1'b1; read_bits(7, w, oe_ok);
    rise_and_sample(b, oe);
    convst_n = 1'b0; wait_n(HALF);
    check(sdata === b && sdata_oe === 1'b1, "R8 output unchanged", {sdata_oe, sdata}, {1'b1, b});
    check(sync_warn === 1'b1, "R8 warn set", sync_warn, 1);
    w = {w[14:0], b};
    fall_edge();
    convst_n = 1'b1; wait_n(HALF);
    read_bits(8, w, oe_ok);
    check(w === 16'h0C3A, "R8 position kept", w, 16'h0C3A);
    cnv_pulse();
    check(sync_warn === 1'b1, "R8 warn sticky", sync_warn, 1);

    // R10 mid-frame load
    load(12'h1E7); cnv_pulse();
    w = '0; oe_ok = 1'b1; read_bits(8, w, oe_ok);
    load(12'hE18);
    read_bits(8, w, oe_ok);
    check(w === 16'h01E7, "R10 current frame unchanged", w, 16'h01E7);
    cnv_pulse();
    w = '0; oe_ok = 1'b1; read_bits(16, w, oe_ok);
    check(w === 16'h0E18, "R10 next frame uses new load", w, 16'h0E18);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule